// File: doc/BRIEF.md
# Four-Tap Sixteen-Phase Pixel Interpolation Filter

This block filters one colour channel along one image axis. Each cycle it can take a window of four neighbouring 8-bit samples and a 4-bit sub-pixel phase. It reads the four signed weights stored for that phase and produces one interpolated 8-bit sample a fixed number of cycles later. Surrounding logic produces the sample windows and phases.

Two independent weight tables are held, one for horizontal use and one for vertical use. A per-sample axis input selects the table. A single-entry write port, addressed by axis, phase and tap, loads the weights. Weight 128 is unity gain. Phase 0 sits on tap 1, and each later phase moves one sixteenth of a sample toward tap 2. A nearest-neighbour table therefore puts 128 on tap 1 for phases 0 to 7 and on tap 2 for phases 8 to 15.

Top module: `polyfir_top`

## Requirements
- R1: While reset is asserted and after its release, with no sample issued, out_valid_o is 0 and out_pix_o is 0.
- R2: A sample issued with in_valid_i high at a clock edge produces out_valid_o high exactly three rising edges later. out_valid_o is never high without a matching issued sample.
- R3: The output equals S = sum over k of w[k]*x[k], arithmetically shifted right by 7 (floor), then clamped to 0..255. x[k] is the unsigned sample at in_win_i bits [8k+7:8k]. w[k] is the 9-bit two's complement weight for tap k of the selected row.
- R4: A row of weights (tap0..tap3) = 0,128,0,0 reproduces x[1] exactly, and a row of 0,0,128,0 reproduces x[2] exactly.
- R5: in_axis_i = 0 selects the horizontal table and 1 the vertical table. A write to one table leaves every output computed from the other table unchanged.
- R6: A weight write with wr_en_i high at an edge is not seen by a sample issued at that same edge. It is seen by every sample issued at a later edge.
- R7: When S shifted right by 7 is negative, the output is 0. When it exceeds 255, the output is 255.
- R8: While no sample is in flight, out_valid_o stays 0 and out_pix_o keeps its last value.
- R9: in_phase_i picks the row in the selected table. A write stores wr_coef_i at the entry named by wr_axis_i, wr_phase_i and wr_tap_i, and leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the pipeline and both tables |
| wr_en_i | input | 1 | Weight write strobe |
| wr_axis_i | input | 1 | Table to write: 0 horizontal, 1 vertical |
| wr_phase_i | input | 4 | Row (phase) to write |
| wr_tap_i | input | 2 | Tap to write |
| wr_coef_i | input | 9 | Weight, two's complement |
| in_valid_i | input | 1 | Sample issue strobe |
| in_axis_i | input | 1 | Table to read: 0 horizontal, 1 vertical |
| in_phase_i | input | 4 | Sub-pixel phase of the sample |
| in_win_i | input | 32 | Four samples; tap k at bits [8k+7:8k] |
| out_valid_o | output | 1 | Filtered sample valid |
| out_pix_o | output | 8 | Filtered sample |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 9-bit weights, four taps and sixteen phases. With these values every row of both tables can be loaded and exercised in a short run. The bench loads a nearest-neighbour horizontal table and a linear-ramp vertical table, then sweeps all phases. It also loads rows whose sums drive the accumulator past both clamp limits. The three-cycle latency and the write-versus-read ordering at one edge are checked directly at this size.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;

  typedef enum logic {
    AXIS_H = 1'b0,
    AXIS_V = 1'b1
  } axis_e;

  localparam int unsigned NUM_AXES = 2;

endpackage

// File: rtl/polyfir_coef_bank.sv
module polyfir_coef_bank
  import polyfir_pkg::*;
#(
  parameter int unsigned COEF_W  = 9,
  parameter int unsigned TAPS    = 4,
  parameter int unsigned PHASES  = 16,
  localparam int unsigned PH_W   = $clog2(PHASES),
  localparam int unsigned TAP_W  = $clog2(TAPS),
  localparam int unsigned ROW_W  = TAPS * COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_axis_i,
  input  logic [PH_W-1:0]   wr_phase_i,
  input  logic [TAP_W-1:0]  wr_tap_i,
  input  logic [COEF_W-1:0] wr_coef_i,
  input  logic              rd_axis_i,
  input  logic [PH_W-1:0]   rd_phase_i,
  output logic [ROW_W-1:0]  rd_row_o
);

  logic [COEF_W-1:0] mem_q [NUM_AXES][PHASES][TAPS];

  // one write-enable per axis so each table is its own register bank
  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_axis_i == a[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int p = 0; p < PHASES; p++) begin
          for (int t = 0; t < TAPS; t++) begin
            mem_q[a][p][t] <= '0;
          end
        end
      end else if (wr_hit) begin
        mem_q[a][wr_phase_i][wr_tap_i] <= wr_coef_i;
      end
    end
  end

  // combinational read: a same-edge write is not yet visible
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      rd_row_o[t*COEF_W +: COEF_W] = mem_q[rd_axis_i][rd_phase_i][t];
    end
  end

endmodule

// File: rtl/polyfir_mac.sv
module polyfir_mac #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COEF_W  = 9,
  parameter int unsigned TAPS    = 4,
  localparam int unsigned WIN_W  = TAPS * DATA_W,
  localparam int unsigned ROW_W  = TAPS * COEF_W,
  localparam int unsigned PROD_W = DATA_W + 1 + COEF_W,
  localparam int unsigned SUM_W  = PROD_W + $clog2(TAPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [WIN_W-1:0]        win_i,
  input  logic [ROW_W-1:0]        row_i,
  output logic                    valid_o,
  output logic signed [SUM_W-1:0] sum_o
);

  logic signed [PROD_W-1:0] prod_d [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic                     v1_q;
  logic signed [SUM_W-1:0]  sum_d;

  // stage 1: per-tap multiply
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [PROD_W-1:0] smp_ext;
    logic signed [PROD_W-1:0] cof_ext;
    assign smp_ext = $signed({{(PROD_W-DATA_W){1'b0}}, win_i[t*DATA_W +: DATA_W]});
    assign cof_ext = {{(PROD_W-COEF_W){row_i[t*COEF_W+COEF_W-1]}},
                      row_i[t*COEF_W +: COEF_W]};
    assign prod_d[t] = smp_ext * cof_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        for (int t = 0; t < TAPS; t++) prod_q[t] <= prod_d[t];
      end
    end
  end

  // stage 2: add tree
  always_comb begin
    sum_d = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum_d = sum_d + {{(SUM_W-PROD_W){prod_q[t][PROD_W-1]}}, prod_q[t]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) sum_o <= sum_d;
    end
  end

endmodule

// File: rtl/polyfir_clamp.sv
module polyfir_clamp #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SUM_W   = 20,
  parameter int unsigned FRAC_SH = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       pix_o
);

  localparam logic signed [SUM_W-1:0] PIX_MAX =
    $signed({{(SUM_W-DATA_W){1'b0}}, {DATA_W{1'b1}}});

  logic signed [SUM_W-1:0] shifted;
  logic [DATA_W-1:0]       pix_d;

  assign shifted = sum_i >>> FRAC_SH;

  always_comb begin
    if (shifted < 0)            pix_d = '0;
    else if (shifted > PIX_MAX) pix_d = '1;
    else                        pix_d = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= pix_d;
    end
  end

  AST_CLAMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sum_i < 0) |=> (pix_o == '0)); // R7

  AST_CLAMP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (sum_i >>> FRAC_SH) > PIX_MAX) |=> (pix_o == '1)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pix_o) && !valid_o)); // R8

endmodule

// File: rtl/polyfir_top.sv
module polyfir_top
  import polyfir_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COEF_W  = 9,
  parameter int unsigned TAPS    = 4,
  parameter int unsigned PHASES  = 16,
  parameter int unsigned FRAC_SH = 7,
  localparam int unsigned PH_W   = $clog2(PHASES),
  localparam int unsigned TAP_W  = $clog2(TAPS),
  localparam int unsigned WIN_W  = TAPS * DATA_W,
  localparam int unsigned ROW_W  = TAPS * COEF_W,
  localparam int unsigned PROD_W = DATA_W + 1 + COEF_W,
  localparam int unsigned SUM_W  = PROD_W + $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_axis_i,
  input  logic [PH_W-1:0]   wr_phase_i,
  input  logic [TAP_W-1:0]  wr_tap_i,
  input  logic [COEF_W-1:0] wr_coef_i,
  input  logic              in_valid_i,
  input  logic              in_axis_i,
  input  logic [PH_W-1:0]   in_phase_i,
  input  logic [WIN_W-1:0]  in_win_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_pix_o
);

  logic [ROW_W-1:0]        row;
  logic                    sum_valid;
  logic signed [SUM_W-1:0] sum;

  polyfir_coef_bank #(
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .PHASES (PHASES)
  ) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_axis_i  (wr_axis_i),
    .wr_phase_i (wr_phase_i),
    .wr_tap_i   (wr_tap_i),
    .wr_coef_i  (wr_coef_i),
    .rd_axis_i  (in_axis_i),
    .rd_phase_i (in_phase_i),
    .rd_row_o   (row)
  );

  polyfir_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS)
  ) i_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .win_i   (in_win_i),
    .row_i   (row),
    .valid_o (sum_valid),
    .sum_o   (sum)
  );

  polyfir_clamp #(
    .DATA_W  (DATA_W),
    .SUM_W   (SUM_W),
    .FRAC_SH (FRAC_SH)
  ) i_clamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sum_valid),
    .sum_i   (sum),
    .valid_o (out_valid_o),
    .pix_o   (out_pix_o)
  );

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 3)); // R2

  AST_ISSUE_LAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !out_valid_o) |=> 1'b1 ##1 1'b1 ##1 out_valid_o); // R2

endmodule

// File: tb/test_polyfir_top.sv
module test_polyfir_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_axis = 1'b0;
  logic [3:0] wr_phase = '0;
  logic [1:0] wr_tap = '0;
  logic [8:0] wr_coef = '0;
  logic       in_valid = 1'b0;
  logic       in_axis = 1'b0;
  logic [3:0] in_phase = '0;
  logic [31:0] in_win = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  always #5ns clk = ~clk;

  polyfir_top i_polyfir_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_axis_i   (wr_axis),
    .wr_phase_i  (wr_phase),
    .wr_tap_i    (wr_tap),
    .wr_coef_i   (wr_coef),
    .in_valid_i  (in_valid),
    .in_axis_i   (in_axis),
    .in_phase_i  (in_phase),
    .in_win_i    (in_win),
    .out_valid_o (out_valid),
    .out_pix_o   (out_pix)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int coef_sh [2][16][4];
  int exp_q[$];
  string req_q[$];

  function automatic logic [31:0] mkwin(int a, int b, int c, int d);
    return {d[7:0], c[7:0], b[7:0], a[7:0]};
  endfunction

  function automatic int model(int ax, int ph, logic [31:0] w);
    int s = 0;
    for (int k = 0; k < 4; k++) s += coef_sh[ax][ph][k] * int'(w[k*8 +: 8]);
    s = s >>> 7;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; expectation uses the table before this cycle's write
  task automatic step(bit dw, int wax, int wph, int wtp, int wval,
                      bit ds, int sax, int sph, logic [31:0] win, string req);
    @(negedge clk);
    if (ds) begin
      exp_q.push_back(model(sax, sph, win));
      req_q.push_back(req);
    end
    if (dw) coef_sh[wax][wph][wtp] = wval;
    wr_en = dw; wr_axis = wax[0]; wr_phase = wph[3:0]; wr_tap = wtp[1:0];
    wr_coef = wval[8:0];
    in_valid = ds; in_axis = sax[0]; in_phase = sph[3:0]; in_win = win;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, "");
  endtask

  task automatic wr(int ax, int ph, int tp, int val);
    step(1, ax, ph, tp, val, 0, 0, 0, '0, "");
  endtask

  task automatic smp(int ax, int ph, logic [31:0] win, string req);
    step(0, 0, 0, 0, 0, 1, ax, ph, win, req);
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) idle();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 actual=valid expected=no output");
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, int'(out_pix), e);
      end
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    automatic int last;
    for (int a = 0; a < 2; a++)
      for (int p = 0; p < 16; p++)
        for (int t = 0; t < 4; t++) coef_sh[a][p][t] = 0;

    #1ns;
    check("R1", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_pix), 0);

    // horizontal: nearest neighbour; vertical: linear ramp between taps 1 and 2
    for (int p = 0; p < 16; p++) begin
      wr(0, p, 1, (p < 8) ? 128 : 0);
      wr(0, p, 2, (p < 8) ? 0 : 128);
      wr(1, p, 1, 128 - 8 * p);
      wr(1, p, 2, 8 * p);
    end
    idle();

    // R2 latency probe
    smp(0, 0, mkwin(5, 77, 9, 1), "R2");
    idle(); check("R2", int'(out_valid), 0);
    idle(); check("R2", int'(out_valid), 0);
    idle(); check("R2", int'(out_valid), 1);
    drain();

    // R4 / R9 nearest-neighbour sweep, back to back
    for (int p = 0; p < 16; p++)
      smp(0, p, mkwin(10, 20 + p, 200 - p, 40), (p < 8) ? "R4" : "R9");
    drain();

    // R3 linear sweep with varied windows
    for (int p = 0; p < 16; p++)
      smp(1, p, mkwin(3 * p, 255 - 7 * p, 11 * p + 17, 99), "R3");
    drain();

    // R5 interleaved axes
    for (int p = 0; p < 16; p++)
      smp(p % 2, p, mkwin(1, 130 + p, 60 - p, 2), "R5");
    drain();

    // R3 all four taps, negative weights
    wr(0, 3, 0, -16); wr(0, 3, 1, 80); wr(0, 3, 2, 80); wr(0, 3, 3, -16);
    smp(0, 3, mkwin(50, 120, 90, 200), "R3");
    smp(0, 3, mkwin(0, 33, 250, 7), "R3");
    drain();

    // R7 clamp high and low, plus exact 255
    wr(0, 5, 1, 128); wr(0, 5, 2, 128);
    smp(0, 5, mkwin(0, 200, 250, 0), "R7");
    smp(0, 5, mkwin(0, 100, 155, 0), "R7");
    wr(0, 6, 0, -128); wr(0, 6, 1, 128); wr(0, 6, 2, 0);
    smp(0, 6, mkwin(255, 10, 0, 0), "R7");
    drain();

    // R6 write and sample in one cycle, then sample again
    step(1, 1, 2, 1, 0, 1, 1, 2, mkwin(0, 200, 100, 0), "R6");
    smp(1, 2, mkwin(0, 200, 100, 0), "R6");
    drain();

    // R5 rewrite horizontal, vertical unaffected
    wr(0, 0, 1, 0); wr(0, 0, 2, 64);
    smp(1, 0, mkwin(9, 123, 45, 6), "R5");
    smp(1, 7, mkwin(9, 123, 45, 6), "R5");
    smp(0, 0, mkwin(9, 123, 44, 6), "R9");
    drain();

    // R8 idle hold
    last = int'(out_pix);
    for (int i = 0; i < 4; i++) begin
      idle();
      check("R8", int'(out_valid), 0);
      check("R8", int'(out_pix), last);
    end
    check("R2", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule